// File: doc/BRIEF.md
# VLIW Execute-Packet Dispatcher

This block sits between program memory and the functional-unit slots of a very-long-instruction-word core. It requests one wide fetch packet at a time. Each fetch packet is eight 32-bit instruction words, 256 bits in all. The block cuts the packet into parallel issue groups and hands one group per clock to the slots. Bit 0 of each instruction word is a link flag. A 1 joins the following word to the same group. A 0 closes the group, and the next word starts a new one.

Issue follows slot order. The dispatch bus presents all eight slots at their own positions, with a valid bit per slot. A downstream stall freezes the block completely. A new fetch packet is requested only once every group of the held packet has gone out. Groups never cross a packet boundary. If the last word still carries a set link flag, the group is closed there and a sticky error flag records the malformed packet.

Top module: `vliw_dispatch`

## Requirements
- R1: In the first cycle after reset, fetch_req is high while disp_valid and chain_err are low. disp_valid stays low until a fetch packet has been accepted.
- R2: A fetch packet is accepted on a rising edge where fetch_req and fetch_vld are both high. Slot i of the packet is fetch_data[32*i+31:32*i], and slot 0 is issued first.
- R3: A word whose bit 0 is 1 links the next slot into its group. A word whose bit 0 is 0 ends its group, and the next slot opens a new group.
- R4: Without stall, group k (counting from 0) of a packet accepted at edge E appears on the dispatch outputs right after edge E+1+k. Exactly one group is presented per unstalled edge.
- R5: disp_mask bit i is set exactly for the slots of the presented group. disp_words carries those words unchanged in their own slot positions, and every other slot reads zero. disp_valid is high exactly when disp_mask is nonzero.
- R6: While any group of the held packet is still unissued, fetch_req is low. It goes high in the same cycle that the last group of the packet appears on the outputs.
- R7: Slot 7 always closes a group. If slot 7 has bit 0 set, chain_err rises together with that group and stays high until reset.
- R8: While stall_in is high, the dispatch outputs do not change, fetch_req is low, and no group or packet is consumed.
- R9: fetch_vld and fetch_data have no effect in cycles where fetch_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_in | input | 1 | Downstream stall; freezes the block |
| fetch_req | output | 1 | Requests a new fetch packet |
| fetch_vld | input | 1 | Fetch packet present on fetch_data |
| fetch_data | input | 256 | Eight instruction words, slot 0 in the low bits |
| disp_valid | output | 1 | A group is presented |
| disp_mask | output | 8 | Per-slot valid bits of the presented group |
| disp_words | output | 256 | Slot-aligned words; invalid slots are zero |
| chain_err | output | 1 | Sticky flag: slot 7 had its link bit set |

## Verification
fetch_req is a same-cycle function of the held state and stall_in, so it is checked in the cycle it is driven, after the stall level for that cycle has settled. A group chosen at an unstalled edge is visible just after that edge, and the last-group fetch request and any chain_err change share that same edge. The bench therefore samples on the falling edge. It decides from the stall level held through the previous rising edge whether a fresh group or a frozen copy is due. It keeps a queue of the expected groups and a count of groups still outstanding, so any missing, extra or late group is detected at the edge where it should have appeared.

// File: rtl/vliw_pkg.sv
// Shared sizing for the execute-packet dispatcher.
// Assumes every instruction word carries its link flag in bit 0.
package vliw_pkg;
    localparam int unsigned SLOTS   = 8;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned PKT_W   = SLOTS * WORD_W;
    localparam int unsigned LINK_B  = 0;
endpackage

// File: rtl/vliw_fetch_buf.sv
// Holds one fetch packet and the set of slots still waiting for issue.
// Requests a new packet only when nothing is pending and the core is not
// stalled. Assumes issue_mask is always a subset of the pending slots.
module vliw_fetch_buf #(
    parameter int unsigned SLOTS  = vliw_pkg::SLOTS,
    parameter int unsigned WORD_W = vliw_pkg::WORD_W,
    localparam int unsigned PKT_W = SLOTS * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_in,
    input  logic             fetch_vld,
    input  logic [PKT_W-1:0] fetch_data,
    input  logic [SLOTS-1:0] issue_mask,
    output logic             fetch_req,
    output logic [PKT_W-1:0] pkt_words,
    output logic [SLOTS-1:0] pend
);
    logic take;

    // Request when the held packet is fully issued and not frozen.
    always_comb begin
        fetch_req = (pend == '0) && !stall_in;
        take      = fetch_req && fetch_vld;
    end

    // Load a new packet or retire the slots issued this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= '0;
            pkt_words <= '0;
        end else if (!stall_in) begin
            if (take) begin
                pkt_words <= fetch_data;
                pend      <= '1;
            end else begin
                pend      <= pend & ~issue_mask;
            end
        end
    end

    p_load_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pend == {SLOTS{1'b1}}));
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_in |=> $stable(pend) && $stable(pkt_words));
    p_no_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> !fetch_req);
endmodule

// File: rtl/vliw_group_find.sv
// Combinational search for the next issue group. It starts at the lowest
// pending slot and runs through linked words. The last slot always ends
// the group. Assumes the pending slots form a contiguous run up to the
// top slot.
module vliw_group_find #(
    parameter int unsigned SLOTS = vliw_pkg::SLOTS
) (
    input  logic [SLOTS-1:0] pend,
    input  logic [SLOTS-1:0] link,
    output logic [SLOTS-1:0] grp,
    output logic             forced
);
    // Walk the slots, collecting pending words until a link bit is clear.
    always_comb begin
        logic closed;
        closed = 1'b0;
        grp    = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (pend[i] && !closed) begin
                grp[i] = 1'b1;
                if (!link[i]) closed = 1'b1;
            end
        end
        forced = grp[SLOTS-1] && link[SLOTS-1];
    end
endmodule

// File: rtl/vliw_issue_reg.sv
// Registers the dispatched group and masks unused slots to zero.
// Keeps the sticky error for a group closed by the slot-7 boundary.
// Assumes grp and forced come from the same cycle's search.
module vliw_issue_reg #(
    parameter int unsigned SLOTS  = vliw_pkg::SLOTS,
    parameter int unsigned WORD_W = vliw_pkg::WORD_W,
    localparam int unsigned PKT_W = SLOTS * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_in,
    input  logic [SLOTS-1:0] grp,
    input  logic             forced,
    input  logic [PKT_W-1:0] pkt_words,
    output logic             disp_valid,
    output logic [SLOTS-1:0] disp_mask,
    output logic [PKT_W-1:0] disp_words,
    output logic             chain_err
);
    logic [PKT_W-1:0] keep;

    // Widen each slot's select bit across its word.
    for (genvar g = 0; g < SLOTS; g++) begin : g_keep
        assign keep[g*WORD_W +: WORD_W] = {WORD_W{grp[g]}};
    end

    // Capture the group unless stalled; latch the boundary error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid <= 1'b0;
            disp_mask  <= '0;
            disp_words <= '0;
            chain_err  <= 1'b0;
        end else if (!stall_in) begin
            disp_valid <= |grp;
            disp_mask  <= grp;
            disp_words <= pkt_words & keep;
            if (forced) chain_err <= 1'b1;
        end
    end

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_err |=> chain_err);
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_in |=> $stable(disp_mask) && $stable(disp_words) && $stable(disp_valid));
    p_valid_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid == (disp_mask != '0));
endmodule

// File: rtl/vliw_dispatch.sv
// Top of the execute-packet dispatcher: fetch buffer, group search and
// issue register. One group leaves per unstalled clock; the next fetch
// packet is requested once the held one is used up.
module vliw_dispatch #(
    parameter int unsigned SLOTS  = vliw_pkg::SLOTS,
    parameter int unsigned WORD_W = vliw_pkg::WORD_W,
    localparam int unsigned PKT_W = SLOTS * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_in,
    output logic             fetch_req,
    input  logic             fetch_vld,
    input  logic [PKT_W-1:0] fetch_data,
    output logic             disp_valid,
    output logic [SLOTS-1:0] disp_mask,
    output logic [PKT_W-1:0] disp_words,
    output logic             chain_err
);
    logic [PKT_W-1:0] pkt_words;
    logic [SLOTS-1:0] pend;
    logic [SLOTS-1:0] link;
    logic [SLOTS-1:0] grp;
    logic             forced;

    // Pull the link flag out of each held word.
    for (genvar g = 0; g < SLOTS; g++) begin : g_link
        assign link[g] = pkt_words[g*WORD_W + vliw_pkg::LINK_B];
    end

    vliw_fetch_buf #(.SLOTS(SLOTS), .WORD_W(WORD_W)) buf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_in   (stall_in),
        .fetch_vld  (fetch_vld),
        .fetch_data (fetch_data),
        .issue_mask (grp),
        .fetch_req  (fetch_req),
        .pkt_words  (pkt_words),
        .pend       (pend)
    );

    vliw_group_find #(.SLOTS(SLOTS)) find_i (
        .pend   (pend),
        .link   (link),
        .grp    (grp),
        .forced (forced)
    );

    vliw_issue_reg #(.SLOTS(SLOTS), .WORD_W(WORD_W)) issue_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_in   (stall_in),
        .grp        (grp),
        .forced     (forced),
        .pkt_words  (pkt_words),
        .disp_valid (disp_valid),
        .disp_mask  (disp_mask),
        .disp_words (disp_words),
        .chain_err  (chain_err)
    );

    p_grp_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grp & ~pend) == '0);
    p_issue_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_in && pend != '0) |=> disp_valid);
    p_idle_no_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_in && pend == '0) |=> !disp_valid);
endmodule

// File: tb/vliw_dispatch_tb_top.sv
`timescale 1ns/1ps
module vliw_dispatch_tb_top;
    localparam int S = 8;
    localparam int W = 32;
    localparam int PW = S * W;
    localparam int NPKT = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall_in = 1'b0;
    logic fetch_vld = 1'b0;
    logic [PW-1:0] fetch_data = '0;
    logic fetch_req, disp_valid, chain_err;
    logic [S-1:0] disp_mask;
    logic [PW-1:0] disp_words;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [S-1:0]  q_mask [0:63];
    logic [PW-1:0] q_words[0:63];
    bit            q_err  [0:63];
    int q_head = 0;
    int q_tail = 0;
    int outstanding = 0;
    bit exp_err = 0;

    always #2 clk = ~clk;

    vliw_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .stall_in(stall_in),
        .fetch_req(fetch_req), .fetch_vld(fetch_vld), .fetch_data(fetch_data),
        .disp_valid(disp_valid), .disp_mask(disp_mask),
        .disp_words(disp_words), .chain_err(chain_err)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Builds one packet; the first few are directed corner cases.
    function automatic logic [PW-1:0] make_pkt(input int idx);
        logic [PW-1:0] p;
        int dens;
        dens = $urandom % 3;
        for (int i = 0; i < S; i++) begin
            p[i*W +: W] = $urandom;
            case (idx)
                0: p[i*W] = 1'b0;
                1: p[i*W] = 1'b1;
                2: p[i*W] = i[0];
                3: p[i*W] = (i != S-1);
                default: p[i*W] = (dens == 0) ? 1'b0 :
                                  (dens == 1) ? 1'(($urandom % 2) == 0) :
                                                1'(($urandom % 8) != 0);
            endcase
        end
        return p;
    endfunction

    // Splits a packet into expected groups (R3, R7) and queues them.
    task automatic push_groups(input logic [PW-1:0] p);
        logic [S-1:0] cur;
        logic [PW-1:0] keep;
        cur = '0;
        for (int i = 0; i < S; i++) begin
            cur[i] = 1'b1;
            if (!p[i*W] || i == S-1) begin
                keep = '0;
                for (int k = 0; k < S; k++) keep[k*W +: W] = {W{cur[k]}};
                q_mask[q_tail % 64]  = cur;
                q_words[q_tail % 64] = p & keep;
                q_err[q_tail % 64]   = (i == S-1) && p[i*W];
                q_tail++;
                outstanding++;
                cur = '0;
            end
        end
    endtask

    initial begin
        int pk_idx;
        bit accepted;
        bit was_stall;
        logic [S-1:0] last_mask;
        logic [PW-1:0] last_words;
        logic last_valid;
        logic [PW-1:0] offered;
        void'($urandom(32'h5eed_1234));
        pk_idx = 0;
        last_mask = '0; last_words = '0; last_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #0.5;
        chk(fetch_req == 1'b1, "R1 fetch_req after reset", PW'(fetch_req), PW'(1));
        chk(disp_valid == 1'b0, "R1 disp_valid after reset", PW'(disp_valid), PW'(0));
        chk(chain_err == 1'b0, "R1 chain_err after reset", PW'(chain_err), PW'(0));
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (pk_idx >= NPKT && outstanding == 0 && cyc > 50) break;
            stall_in = (cyc > 30) && (($urandom % 5) == 0);
            #0.5;
            chk(fetch_req == ((outstanding == 0) && !stall_in), "R6/R8 fetch_req",
                PW'(fetch_req), PW'((outstanding == 0) && !stall_in));
            offered = '0;
            if (fetch_req && pk_idx < NPKT && (cyc < 10 || ($urandom % 10) < 7)) begin
                offered = make_pkt(pk_idx);
                fetch_vld = 1'b1;
                fetch_data = offered;
                pk_idx++;
            end else begin
                fetch_vld = (($urandom % 2) == 0);   // R9 garbage when not requested
                fetch_data = {8{$urandom}};
            end
            accepted = fetch_req && fetch_vld;
            was_stall = stall_in;
            @(posedge clk);
            @(negedge clk);
            if (was_stall) begin
                chk(disp_valid == last_valid && disp_mask == last_mask && disp_words == last_words,
                    "R8 outputs held", disp_words, last_words);
            end else if (outstanding > 0) begin
                chk(disp_valid == 1'b1, "R4 group due", PW'(disp_valid), PW'(1));
                chk(disp_mask == q_mask[q_head % 64], "R3/R5 mask",
                    PW'(disp_mask), PW'(q_mask[q_head % 64]));
                chk(disp_words == q_words[q_head % 64], "R2/R5 words",
                    disp_words, q_words[q_head % 64]);
                if (q_err[q_head % 64]) exp_err = 1'b1;
                q_head++;
                outstanding--;
            end else begin
                chk(disp_valid == 1'b0 && disp_mask == '0, "R1/R4 idle",
                    PW'(disp_mask), PW'(0));
            end
            chk(chain_err == exp_err, "R7 chain_err", PW'(chain_err), PW'(exp_err));
            if (accepted && offered != '0) push_groups(offered);
            else if (accepted) push_groups(fetch_data);
            last_valid = disp_valid; last_mask = disp_mask; last_words = disp_words;
        end
        chk(outstanding == 0 && pk_idx == NPKT, "R4 all groups drained",
            PW'(outstanding), PW'(0));
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule